// File: doc/BRIEF.md
# Power-On Self-Test Sequencer

This block gates a one-shot signature-verification service behind a fixed start-up self-test sequence. It sits between the platform and a shared crypto engine port. After reset it runs three self-test steps in a fixed order: a hash known-answer test, a signature known-answer test, and a firmware integrity check. The integrity check compares a digest computed at run time with a digest fixed when the design is built. Each step uses a one-cycle start pulse, a done strobe and a pass flag, and a watchdog limits how long each step may take.

While the tests run, and after any failure, the data path is held at zero and service requests are refused. A 32-bit status word reports progress, the step that failed, and the verdict of the single verification. Once the verification has completed, the block parks in a terminal unloaded state. It runs again only after a new reset. An enable input, sampled on the first clock edge after reset release, decides whether the sequence runs at all.

Top module: `selftest_gate`

## Requirements
- R1: The steps start in a fixed order, each with a single-cycle `eng_start_o` pulse. The `eng_sel_o` values are 0 for the hash known-answer test, then 1 for the signature known-answer test, then 2 for the integrity check. The verification uses `eng_sel_o` = 3, and it starts only once the three tests have passed.
- R2: The integrity step passes only when `digest_i` equals the build-time digest parameter `GOLD_DIGEST` in the cycle that `eng_done_i` is high. `eng_pass_i` is ignored for this step.
- R3: A failed hash known-answer test sets `status_o` to 0xAA0000FB. A failed signature known-answer test sets it to 0xAA0000FC. A failed integrity check sets it to 0xAA0000FD.
- R4: While a self-test runs, `status_o` reads 0xA5000001, `svc_dout_o` is zero and `svc_ack_o` stays low.
- R5: After any self-test failure the block stays in error until reset. The status is unchanged, no engine start is issued, no request is acknowledged, and `svc_dout_o` is zero.
- R6: After all three tests pass, `status_o` reads 0xA5000002 and `svc_dout_o` follows `svc_din_i`.
- R7: In the operational state, a high `svc_req_i` is acknowledged on `svc_ack_o` in that cycle and starts exactly one verification. While the verification runs, `status_o` reads 0xA5000003. A pass verdict gives `status_o` 0xA5000010 and a fail verdict gives 0xA5000011. `result_valid_o` is high from then on and `result_pass_o` carries the verdict.
- R8: The unloaded state is terminal. Later requests are not acknowledged, no engine start is issued, `svc_dout_o` is zero, and the status and verdict do not change.
- R9: If `feat_en_i` is 0 on the first clock edge after reset release, `status_o` reads 0xA50000DD. No engine start and no acknowledge occur until the next reset.
- R10: If `eng_done_i` does not arrive within `TMO` cycles after a start, that step counts as failed. A self-test that times out gets its error code, and a verification that times out gets the fail verdict.
- R11: `status_o` is zero while `rst_n` is low. Otherwise it is never zero, and in the idle cycle after reset release it reads 0xA5000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en_i | input | 1 | Feature enable, sampled once after reset |
| eng_start_o | output | 1 | One-cycle engine start pulse |
| eng_sel_o | output | 2 | Engine operation select (0 hash KAT, 1 signature KAT, 2 integrity digest, 3 verify) |
| eng_done_i | input | 1 | Engine completion strobe |
| eng_pass_i | input | 1 | Engine pass flag, valid with done |
| digest_i | input | DIG_W | Run-time image digest, valid with done |
| svc_req_i | input | 1 | Verification service request |
| svc_ack_o | output | 1 | Request accepted |
| svc_din_i | input | DW | Service data from the engine side |
| svc_dout_o | output | DW | Gated service data output |
| status_o | output | 32 | Progress, error and verdict code |
| result_valid_o | output | 1 | Verification finished (terminal) |
| result_pass_o | output | 1 | Verification verdict |

## Verification
On every cycle the assertions check the following: the start strobe is a single-cycle pulse and is tied to the right phase and select, the data path and acknowledge stay blocked during testing, and the error, disabled and unloaded states hold still. An independent counter bounds each engine wait to the watchdog window. Other behaviour is visible only through the bench's directed scenarios, each of which drives a behavioural engine model with chosen latencies, pass flags and digests. These scenarios show the order of the steps, which error code goes with which failing step, the integrity check ignoring the pass flag, the two verdicts, and timeouts of both kinds.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_OFF, PH_HKAT, PH_SKAT, PH_INTG, PH_OPER, PH_VER, PH_ERR, PH_DONE
  } phase_e;

  localparam logic [1:0] SEL_HKAT = 2'd0;
  localparam logic [1:0] SEL_SKAT = 2'd1;
  localparam logic [1:0] SEL_INTG = 2'd2;
  localparam logic [1:0] SEL_VER  = 2'd3;

  localparam logic [31:0] CODE_IDLE   = 32'hA500_0000;
  localparam logic [31:0] CODE_TEST   = 32'hA500_0001;
  localparam logic [31:0] CODE_OPER   = 32'hA500_0002;
  localparam logic [31:0] CODE_BUSY   = 32'hA500_0003;
  localparam logic [31:0] CODE_VPASS  = 32'hA500_0010;
  localparam logic [31:0] CODE_VFAIL  = 32'hA500_0011;
  localparam logic [31:0] CODE_OFF    = 32'hA500_00DD;
  localparam logic [31:0] CODE_E_HASH = 32'hAA00_00FB;
  localparam logic [31:0] CODE_E_SIG  = 32'hAA00_00FC;
  localparam logic [31:0] CODE_E_INTG = 32'hAA00_00FD;

  // engine select for a step phase
  function automatic logic [1:0] sel_of(phase_e ph);
    case (ph)
      PH_HKAT: return SEL_HKAT;
      PH_SKAT: return SEL_SKAT;
      PH_INTG: return SEL_INTG;
      default: return SEL_VER;
    endcase
  endfunction

  // error code for the self-test that failed
  function automatic logic [31:0] err_code_of(phase_e failed);
    case (failed)
      PH_HKAT: return CODE_E_HASH;
      PH_SKAT: return CODE_E_SIG;
      default: return CODE_E_INTG;
    endcase
  endfunction

  // exact-match integrity comparison
  function automatic logic digest_match(logic [255:0] a, logic [255:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/stg_step_ctl.sv
module stg_step_ctl #(
  parameter int TMO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic pass_i,
  output logic busy_o,
  output logic fin_o,
  output logic ok_o
);
  localparam int CW = $clog2(TMO + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          tmo;

  assign tmo    = busy_q & ~done_i & (cnt_q == CW'(TMO - 1));
  assign fin_o  = busy_q & (done_i | tmo);
  assign ok_o   = busy_q & done_i & pass_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (fin_o) busy_q <= 1'b0;
      else       cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stg_status_enc.sv
module stg_status_enc
  import stg_pkg::*;
(
  input  phase_e      phase_i,
  input  phase_e      failed_i,
  input  logic        verdict_i,
  output logic [31:0] code_o
);
  always_comb begin
    case (phase_i)
      PH_IDLE:                   code_o = CODE_IDLE;
      PH_OFF:                    code_o = CODE_OFF;
      PH_HKAT, PH_SKAT, PH_INTG: code_o = CODE_TEST;
      PH_OPER:                   code_o = CODE_OPER;
      PH_VER:                    code_o = CODE_BUSY;
      PH_ERR:                    code_o = err_code_of(failed_i);
      PH_DONE:                   code_o = verdict_i ? CODE_VPASS : CODE_VFAIL;
      default:                   code_o = CODE_IDLE;
    endcase
  end
endmodule

// File: rtl/selftest_gate.sv
module selftest_gate
  import stg_pkg::*;
#(
  parameter int               DW          = 32,
  parameter int               DIG_W       = 64,
  parameter int               TMO         = 64,
  parameter logic [DIG_W-1:0] GOLD_DIGEST = 64'h0123_4567_89AB_CDEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_en_i,
  output logic             eng_start_o,
  output logic [1:0]       eng_sel_o,
  input  logic             eng_done_i,
  input  logic             eng_pass_i,
  input  logic [DIG_W-1:0] digest_i,
  input  logic             svc_req_i,
  output logic             svc_ack_o,
  input  logic [DW-1:0]    svc_din_i,
  output logic [DW-1:0]    svc_dout_o,
  output logic [31:0]      status_o,
  output logic             result_valid_o,
  output logic             result_pass_o
);
  phase_e phase_q, failed_q;
  logic   launch_q, verdict_q;
  logic   step_wait, step_fin, step_ok, pass_eff;
  logic   testing, data_open;
  logic [31:0] code;

  assign testing   = (phase_q == PH_HKAT) || (phase_q == PH_SKAT) || (phase_q == PH_INTG);
  assign data_open = (phase_q == PH_OPER) || (phase_q == PH_VER);
  assign pass_eff  = (phase_q == PH_INTG)
                   ? digest_match(256'(digest_i), 256'(GOLD_DIGEST))
                   : eng_pass_i;

  stg_step_ctl #(.TMO(TMO)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(launch_q),
    .done_i (eng_done_i),
    .pass_i (pass_eff),
    .busy_o (step_wait),
    .fin_o  (step_fin),
    .ok_o   (step_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      failed_q  <= PH_IDLE;
      launch_q  <= 1'b0;
      verdict_q <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (feat_en_i) begin
            phase_q  <= PH_HKAT;
            launch_q <= 1'b1;
          end else begin
            phase_q <= PH_OFF;
          end
        end
        PH_HKAT, PH_SKAT, PH_INTG: begin
          if (step_fin) begin
            if (!step_ok) begin
              phase_q  <= PH_ERR;
              failed_q <= phase_q;
            end else if (phase_q == PH_HKAT) begin
              phase_q  <= PH_SKAT;
              launch_q <= 1'b1;
            end else if (phase_q == PH_SKAT) begin
              phase_q  <= PH_INTG;
              launch_q <= 1'b1;
            end else begin
              phase_q <= PH_OPER;
            end
          end
        end
        PH_OPER: begin
          if (svc_req_i) begin
            phase_q  <= PH_VER;
            launch_q <= 1'b1;
          end
        end
        PH_VER: begin
          if (step_fin) begin
            phase_q   <= PH_DONE;
            verdict_q <= step_ok;
          end
        end
        default: ;
      endcase
    end
  end

  stg_status_enc u_enc (
    .phase_i  (phase_q),
    .failed_i (failed_q),
    .verdict_i(verdict_q),
    .code_o   (code)
  );

  assign eng_start_o    = launch_q;
  assign eng_sel_o      = sel_of(phase_q);
  assign svc_ack_o      = (phase_q == PH_OPER) && svc_req_i;
  assign svc_dout_o     = data_open ? svc_din_i : '0;
  assign status_o       = rst_n ? code : 32'h0;
  assign result_valid_o = (phase_q == PH_DONE);
  assign result_pass_o  = (phase_q == PH_DONE) && verdict_q;
endmodule

// File: rtl/stg_chk.sv
module stg_chk
  import stg_pkg::*;
#(
  parameter int DW  = 32,
  parameter int TMO = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_start_o,
  input logic [1:0]    eng_sel_o,
  input logic          svc_ack_o,
  input logic [DW-1:0] svc_dout_o,
  input logic [31:0]   status_o,
  input logic          result_valid_o,
  input logic          result_pass_o,
  input logic          step_wait
);
  logic is_err;
  logic [31:0] wd_cnt;

  assign is_err = (status_o == CODE_E_HASH) || (status_o == CODE_E_SIG) ||
                  (status_o == CODE_E_INTG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wd_cnt <= '0;
    else if (step_wait) wd_cnt <= wd_cnt + 1;
    else                wd_cnt <= '0;
  end

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  // R1
  start_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> ((status_o == CODE_TEST) && (eng_sel_o != SEL_VER)) ||
                    ((status_o == CODE_BUSY) && (eng_sel_o == SEL_VER)));

  // R4
  test_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == CODE_TEST) |-> (svc_dout_o == '0) && !svc_ack_o);

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_err |=> $stable(status_o) && !eng_start_o && !svc_ack_o && (svc_dout_o == '0));

  // R8
  unload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> result_valid_o && $stable(result_pass_o) && $stable(status_o)
                       && !eng_start_o && !svc_ack_o);

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == CODE_OFF) |=> (status_o == CODE_OFF) && !eng_start_o && !svc_ack_o);

  // R10
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_wait |-> (wd_cnt < TMO));

  // R11
  nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 32'h0);
endmodule

bind selftest_gate stg_chk #(.DW(DW), .TMO(TMO)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .eng_start_o   (eng_start_o),
  .eng_sel_o     (eng_sel_o),
  .svc_ack_o     (svc_ack_o),
  .svc_dout_o    (svc_dout_o),
  .status_o      (status_o),
  .result_valid_o(result_valid_o),
  .result_pass_o (result_pass_o),
  .step_wait     (step_wait)
);

// File: tb/selftest_gate_bench.sv
`timescale 1ns/1ps
module selftest_gate_bench;
  localparam logic [63:0] GOLD = 64'h0123_4567_89AB_CDEF;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en_i = 1'b1;
  logic        eng_start_o;
  logic [1:0]  eng_sel_o;
  logic        eng_done_i = 1'b0;
  logic        eng_pass_i = 1'b0;
  logic [63:0] digest_i = '0;
  logic        svc_req_i = 1'b0;
  logic        svc_ack_o;
  logic [31:0] svc_din_i = 32'hCAFE_F00D;
  logic [31:0] svc_dout_o;
  logic [31:0] status_o;
  logic        result_valid_o;
  logic        result_pass_o;

  always #4 clk = ~clk;

  selftest_gate u_selftest_gate (.*);

  int n_tests = 0;
  int n_fail  = 0;

  // engine model configuration: latency 0 means never answers
  int          lat  [4];
  logic        pflag[4];
  logic [63:0] dig_val;
  int          log_sel[16];
  int          n_starts;
  int          start_len_bad;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // behavioural engine
  initial begin
    int cnt;
    int cur;
    logic prev_start;
    cnt = 0; cur = 0; prev_start = 1'b0;
    forever begin
      @(negedge clk);
      eng_done_i = 1'b0;
      eng_pass_i = 1'b0;
      if (!rst_n) begin
        cnt = 0; prev_start = 1'b0;
      end else begin
        if (cnt > 0) begin
          cnt--;
          if (cnt == 0) begin
            eng_done_i = 1'b1;
            eng_pass_i = pflag[cur];
            digest_i   = dig_val;
          end
        end
        if (eng_start_o) begin
          if (prev_start) start_len_bad++;
          if (n_starts < 16) log_sel[n_starts] = int'(eng_sel_o);
          n_starts++;
          cur = int'(eng_sel_o);
          cnt = lat[cur];
        end
        prev_start = eng_start_o;
      end
    end
  end

  task automatic do_reset(input logic en);
    @(negedge clk);
    rst_n = 1'b0;
    feat_en_i = en;
    svc_req_i = 1'b0;
    n_starts = 0;
    start_len_bad = 0;
    repeat (3) @(negedge clk);
    chk(status_o == 32'h0, "R11 reset status", status_o, 32'h0);
    rst_n = 1'b1;
    #1;
    chk(status_o == 32'hA500_0000, "R11 idle status", status_o, 32'hA500_0000);
  endtask

  task automatic cfg(input int l0, l1, l2, l3, input logic p0, p1, p2, p3,
                     input logic [63:0] d);
    lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
    pflag[0] = p0; pflag[1] = p1; pflag[2] = p2; pflag[3] = p3;
    dig_val = d;
  endtask

  // wait for a status code; check blocking while testing (R4)
  task automatic wait_status(input logic [31:0] code, input int max, input string req);
    int i;
    for (i = 0; i < max; i++) begin
      @(negedge clk);
      #1;
      if (status_o == code) break;
      if (status_o == 32'hA500_0001 && (svc_ack_o || svc_dout_o != 0)) begin
        chk(1'b0, "R4 blocked while testing", svc_dout_o, 32'h0);
      end
    end
    chk(status_o == code, req, status_o, code);
  endtask

  task automatic hold_check(input int cycles, input logic [31:0] code, input string req);
    int bad;
    int s0;
    bad = 0;
    s0 = n_starts;
    svc_req_i = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      if (status_o != code || svc_ack_o || svc_dout_o != 0) bad++;
    end
    svc_req_i = 1'b0;
    chk(bad == 0, req, status_o, code);
    chk(n_starts == s0, {req, " no start"}, n_starts, s0);
  endtask

  task automatic t_nominal;
    cfg(3, 4, 5, 3, 1, 1, 1, 1, GOLD);
    do_reset(1'b1);
    svc_req_i = 1'b1;   // request held during tests must be refused (R4)
    wait_status(32'hA500_0002, 200, "R6 operational after tests");
    chk(n_starts == 3 && log_sel[0] == 0 && log_sel[1] == 1 && log_sel[2] == 2,
        "R1 step order", n_starts, 3);
    chk(start_len_bad == 0, "R1 single-cycle start", start_len_bad, 0);
    svc_req_i = 1'b0;
    #1;
    chk(svc_dout_o == svc_din_i, "R6 data passes", svc_dout_o, svc_din_i);
    svc_req_i = 1'b1;
    #1;
    chk(svc_ack_o == 1'b1, "R7 request acked", svc_ack_o, 1);
    @(negedge clk);
    svc_req_i = 1'b0;
    wait_status(32'hA500_0010, 50, "R7 verify pass code");
    chk(result_valid_o && result_pass_o, "R7 verdict pass", result_pass_o, 1);
    chk(n_starts == 4 && log_sel[3] == 3, "R7 one verify start", n_starts, 4);
    hold_check(20, 32'hA500_0010, "R8 unloaded terminal");
  endtask

  task automatic t_verify_fail;
    cfg(2, 2, 2, 2, 1, 1, 1, 0, GOLD);
    do_reset(1'b1);
    wait_status(32'hA500_0002, 200, "R6 operational");
    svc_req_i = 1'b1;
    @(negedge clk);
    svc_req_i = 1'b0;
    wait_status(32'hA500_0011, 50, "R7 verify fail code");
    chk(result_valid_o && !result_pass_o, "R7 verdict fail", result_pass_o, 0);
  endtask

  task automatic t_hash_fail;
    cfg(3, 3, 3, 3, 0, 1, 1, 1, GOLD);
    do_reset(1'b1);
    wait_status(32'hAA00_00FB, 100, "R3 hash KAT error");
    hold_check(30, 32'hAA00_00FB, "R5 error absorbing");
  endtask

  task automatic t_sig_fail;
    cfg(3, 3, 3, 3, 1, 0, 1, 1, GOLD);
    do_reset(1'b1);
    wait_status(32'hAA00_00FC, 100, "R3 signature KAT error");
    chk(n_starts == 2, "R1 no integrity after failure", n_starts, 2);
  endtask

  task automatic t_digest_bad;
    cfg(3, 3, 3, 3, 1, 1, 1, 1, GOLD ^ 64'h1);
    do_reset(1'b1);
    wait_status(32'hAA00_00FD, 100, "R2 R3 digest mismatch error");
  endtask

  task automatic t_digest_flag_ignored;
    cfg(3, 3, 3, 3, 1, 1, 0, 1, GOLD);
    do_reset(1'b1);
    wait_status(32'hA500_0002, 100, "R2 flag ignored on match");
  endtask

  task automatic t_timeout;
    cfg(3, 0, 3, 3, 1, 1, 1, 1, GOLD);
    do_reset(1'b1);
    wait_status(32'hAA00_00FC, TMO + 40, "R10 KAT timeout");
    cfg(3, 3, 3, 0, 1, 1, 1, 1, GOLD);
    do_reset(1'b1);
    wait_status(32'hA500_0002, 100, "R6 operational");
    svc_req_i = 1'b1;
    @(negedge clk);
    svc_req_i = 1'b0;
    wait_status(32'hA500_0011, TMO + 40, "R10 verify timeout");
  endtask

  task automatic t_disabled;
    cfg(3, 3, 3, 3, 1, 1, 1, 1, GOLD);
    do_reset(1'b0);
    @(negedge clk);
    #1;
    chk(status_o == 32'hA500_00DD, "R9 disabled code", status_o, 32'hA500_00DD);
    hold_check(40, 32'hA500_00DD, "R9 disabled idle");
  endtask

  initial begin
    fork
      begin
        t_nominal();
        t_verify_fail();
        t_hash_fail();
        t_sig_fail();
        t_digest_bad();
        t_digest_flag_ignored();
        t_timeout();
        t_disabled();
      end
      begin
        repeat (100000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule